// File: doc/BRIEF.md
# Byte Register Window Bridge

This block lets a bus master reach a 256-entry file of 8-bit registers through one 32-bit window word. The window packs the byte address, the byte to write, a write strobe, a busy flag, a sticky error flag and the last byte read back. One host write with the strobe set performs an internal byte write. A host write with the strobe clear starts an internal read, and busy shows while it runs. The host polls the window until busy drops and then takes the byte from the top of the word.

The internal side is a byte-wide register port. Read data is valid a fixed number of clock edges after the request, and that number is the parameter `RD_LAT` (at least 2). The bridge does not queue requests. A host write that arrives while a read is still running is dropped, and the drop sets the sticky error flag.

Top module: `byte_window_bridge`

## Requirements
- R1: After reset the window reads all zeros, and neither `reg_wr` nor `reg_rd` is high.
- R2: Window layout as read by the host: bits 7:0 hold the last accepted address, 15:8 the last accepted write byte, 21:16 read as zero, 22 is the error flag, 23 is busy, and 31:24 hold the read byte.
- R3: An accepted host write with bit 16 set raises `reg_wr` for exactly the one cycle after the write edge. In that cycle `reg_addr` equals bits 7:0 of the write and `reg_wdata` equals bits 15:8. Busy stays low.
- R4: An accepted host write with bit 16 clear raises busy and a one-cycle `reg_rd` in the cycle after the write edge, with `reg_addr` equal to bits 7:0.
- R5: The bridge samples `reg_rdata` at the `RD_LAT`-th clock edge after the edge that raised `reg_rd`. At that same edge the sample moves into bits 31:24 and busy falls.
- R6: A host write sampled while busy is high is ignored, including at the edge where busy falls. It starts no internal access, changes neither address nor write byte, and sets the error flag.
- R7: The error flag stays set until an accepted host write has bit 22 set, which clears it. Accepted writes with bit 22 clear leave it as it is.
- R8: The read byte keeps its value until the next read completes. Internal writes do not change it.
- R9: `reg_wr` and `reg_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the window word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current window word |
| reg_wr | output | 1 | Internal byte write strobe |
| reg_rd | output | 1 | Internal read request pulse |
| reg_addr | output | 8 | Internal byte address |
| reg_wdata | output | 8 | Internal write byte |
| reg_rdata | input | 8 | Internal read byte, valid `RD_LAT` edges after the request |

## Verification
Each result has a fixed cycle in which it is due. Address, write byte and error flag change at the host write edge. The `reg_wr` or `reg_rd` pulse and the rise of busy show in the cycle after that edge. The read byte and the fall of busy appear at the `RD_LAT`-th edge after the request.

The bench drives inputs on falling edges and keeps a behavioural reference that updates on rising edges. It compares the whole window and the internal port with that reference at every falling edge. The internal register model drives a valid byte only during the one cycle before the due sampling edge and a filler value otherwise, so a read sampled one edge early or late returns the wrong byte. Host writes are placed at the edge where busy falls to test the end of the ignore window.

// File: rtl/byte_window_bridge.sv
module byte_window_bridge #(
  parameter int RD_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        reg_wr,
  output logic        reg_rd,
  output logic [7:0]  reg_addr,
  output logic [7:0]  reg_wdata,
  input  logic [7:0]  reg_rdata
);
  localparam int CW = $clog2(RD_LAT + 1);

  logic [7:0]    addr_q, wdat_q, rbyte_q;
  logic          busy_q, err_q, wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  wire take = host_wr & ~busy_q;
  wire unused_bits = ^{host_wdata[31:23], host_wdata[21:17]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdat_q  <= '0;
      rbyte_q <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (busy_q) begin
        if (host_wr) err_q <= 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q  <= 1'b0;
          rbyte_q <= reg_rdata;
        end
        cnt_q <= cnt_q - CW'(1);
      end else if (take) begin
        addr_q <= host_wdata[7:0];
        wdat_q <= host_wdata[15:8];
        if (host_wdata[22]) err_q <= 1'b0;
        if (host_wdata[16]) begin
          wr_q <= 1'b1;
        end else begin
          rd_q   <= 1'b1;
          busy_q <= 1'b1;
          cnt_q  <= CW'(RD_LAT);
        end
      end
    end
  end

  assign host_rdata = {rbyte_q, busy_q, err_q, 6'b0, wdat_q, addr_q};
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdat_q;
endmodule

module byte_window_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [7:0]  reg_addr
);
  p_write_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_rdata[23] && host_wdata[16] |=> reg_wr && !host_rdata[23] && reg_addr == $past(host_wdata[7:0]));

  p_read_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_rdata[23] && !host_wdata[16] |=> reg_rd && host_rdata[23]);

  p_ignore_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_rdata[23] |=> host_rdata[22] && !reg_wr && !reg_rd && $stable(reg_addr));

  p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(host_rdata[23]) |-> $stable(host_rdata[31:24]));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));

  p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[21:16] == 6'b0);
endmodule

bind byte_window_bridge byte_window_bridge_chk u_chk (.*);

// File: tb/byte_window_bridge_tb.sv
module byte_window_bridge_tb;
  localparam int RD_LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr, reg_wdata;
  logic [7:0]  reg_rdata = 8'hEE;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  byte_window_bridge #(.RD_LAT(RD_LAT)) u_dut (.*);

  logic [7:0] mem [256];
  int rcnt = -1;
  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    reg_rdata <= 8'hEE;
    if (reg_wr) mem[reg_addr] <= reg_wdata;
    if (reg_rd) rcnt <= RD_LAT - 2;
    else if (rcnt == 1) begin
      reg_rdata <= mem[reg_addr];
      rcnt <= -1;
    end else if (rcnt > 1) rcnt <= rcnt - 1;
  end

  logic [7:0] m_addr = 0, m_wd = 0, m_rb = 0;
  bit m_busy = 0, m_err = 0, m_wr = 0, m_rd = 0;
  int m_left = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr <= 0; m_wd <= 0; m_rb <= 0; m_busy <= 0; m_err <= 0;
      m_wr <= 0; m_rd <= 0; m_left <= 0;
    end else begin
      m_wr <= 0; m_rd <= 0;
      if (m_busy) begin
        if (host_wr) m_err <= 1;
        if (m_left == 1) begin m_busy <= 0; m_rb <= reg_rdata; end
        m_left <= m_left - 1;
      end else if (host_wr) begin
        m_addr <= host_wdata[7:0];
        m_wd <= host_wdata[15:8];
        if (host_wdata[22]) m_err <= 0;
        if (host_wdata[16]) m_wr <= 1;
        else begin m_rd <= 1; m_busy <= 1; m_left <= RD_LAT; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [31:0] ew;
    ew = {m_rb, m_busy, m_err, 6'b0, m_wd, m_addr};
    chk(host_rdata == ew, "R2 R5 R6 R7 R8 window", host_rdata, ew);
    chk({reg_wr, reg_rd, reg_addr, reg_wdata} == {m_wr, m_rd, m_addr, m_wd},
        "R3 R4 R6 internal port", {14'b0, reg_wr, reg_rd, reg_addr, reg_wdata},
        {14'b0, m_wr, m_rd, m_addr, m_wd});
    chk(!(reg_wr && reg_rd), "R9 strobes overlap", {30'b0, reg_wr, reg_rd}, 32'b0);
  end

  task automatic hwrite(input logic [31:0] w);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [7:0] b);
    hwrite({24'h0, a});
    do @(negedge clk); while (host_rdata[23]);
    b = host_rdata[31:24];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    chk(host_rdata == 32'h0 && !reg_wr && !reg_rd, "R1 in reset", host_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rdata == 32'h0, "R1 after reset", host_rdata, 32'h0);

    hwrite({8'h0, 8'h01, 8'hA5, 8'h10});
    chk(reg_wr && reg_addr == 8'h10 && reg_wdata == 8'hA5 && !host_rdata[23],
        "R3 write strobe", {reg_wr, 15'b0, reg_addr, reg_wdata}, {1'b1, 15'b0, 16'h10A5});
    hwrite({8'h0, 8'h01, 8'h3C, 8'hFF});
    hwrite({8'h0, 8'h01, 8'h00, 8'h00});

    hread(8'h10, b);
    chk(b == 8'hA5, "R5 read back 10", {24'b0, b}, 32'hA5);
    hread(8'hFF, b);
    chk(b == 8'h3C, "R5 read back FF", {24'b0, b}, 32'h3C);
    hread(8'h00, b);
    chk(b == 8'h00, "R5 read back 00", {24'b0, b}, 32'h00);
    hread(8'h42, b);
    chk(b == (8'h42 ^ 8'h5A), "R4 R5 untouched reg", {24'b0, b}, {24'b0, 8'h42 ^ 8'h5A});

    hwrite({8'h0, 8'h01, 8'h77, 8'h20});
    chk(host_rdata[31:24] == b, "R8 byte held over write", {24'b0, host_rdata[31:24]}, {24'b0, b});

    hwrite({24'h0, 8'h30});
    hwrite({8'h0, 8'h01, 8'h99, 8'h31});
    chk(host_rdata[22] == 1'b1, "R6 error flag set", {31'b0, host_rdata[22]}, 32'h1);
    do @(negedge clk); while (host_rdata[23]);
    chk(host_rdata[7:0] == 8'h30, "R6 address unchanged", {24'b0, host_rdata[7:0]}, 32'h30);

    keep = host_rdata[31:24];
    hwrite({24'h0, 8'h31});
    repeat (RD_LAT - 2) @(negedge clk);
    hwrite({8'h0, 8'h01, 8'h55, 8'h31});
    chk(!host_rdata[23] && host_rdata[22], "R6 write at busy fall ignored",
        {30'b0, host_rdata[23:22]}, 32'h1);
    chk(host_rdata[31:24] == (8'h31 ^ 8'h5A), "R5 R6 read completes",
        {24'b0, host_rdata[31:24]}, {24'b0, 8'h31 ^ 8'h5A});
    chk(keep == (8'h30 ^ 8'h5A), "R5 previous read byte", {24'b0, keep}, {24'b0, 8'h30 ^ 8'h5A});

    hwrite({8'h0, 8'h01, 8'h12, 8'h40});
    chk(host_rdata[22], "R7 error stays without clear bit", {31'b0, host_rdata[22]}, 32'h1);
    hwrite({8'h0, 8'h41, 8'h34, 8'h41});
    chk(!host_rdata[22], "R7 error cleared", {31'b0, host_rdata[22]}, 32'h0);

    hread(8'h31, b);
    chk(b == (8'h31 ^ 8'h5A), "R6 ignored write did not land", {24'b0, b}, {24'b0, 8'h31 ^ 8'h5A});
    hread(8'h41, b);
    chk(b == 8'h34, "R3 write with clear bit landed", {24'b0, b}, 32'h34);

    for (int k = 0; k < 6; k++) begin
      hwrite({8'h0, 8'h01, 8'(k * 37), 8'(8'hC0 + k)});
      hread(8'(8'hC0 + k), b);
      chk(b == 8'(k * 37), "R3 R5 loop", {24'b0, b}, {24'b0, 8'(k * 37)});
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule